// File: doc/BRIEF.md
# Task Pool with Dependence Counting

This block holds the descriptors of submitted tasks and keeps, for each task, the number of dependencies that are still open. A new task arrives as a stream of beats, one parameter address per beat. The last beat also carries the initial dependence count produced by an external address lookup. Each task is given a pool entry. When its parameters do not fit in one entry, further entries are allocated and linked behind it. A task whose count is zero goes to the ready output at once. Otherwise its count is stored, and every wakeup event for that task lowers the count by one. The task becomes ready when the count reaches zero.

When a finished-task index arrives, the block walks the task's parameters across the whole chain of entries and presents each address on a release handshake towards the lookup. Every entry is returned to the free list once its last parameter has been released. Pool indices come from a free list. That list hands out recycled indices first, in the order they were returned, and otherwise gives out never-used indices in ascending order starting at 0.

Top module: `task_pool`

## Requirements
- R1: After reset, rdy_valid_o, err_o and rel_valid_o are 0, and new_ready_o and fin_ready_o are 1.
- R2: When the last beat of a task whose initial count is 0 is accepted, the next cycle shows rdy_valid_o high for exactly one cycle. rdy_idx_o is the task's head index and rdy_func_o is the function pointer given on its first beat.
- R3: A task with a non-zero initial count is not emitted on insertion. Each wakeup lowers its count by one. The cycle after the wakeup that takes the count from 1 to 0, the task is emitted once.
- R4: A wakeup on a count that is already 0 sets err_o for one cycle in the next cycle, emits nothing and leaves the count at 0, so a repeat wakeup reports the error again.
- R5: One entry holds PARAMS addresses. A task with more parameters takes extra entries from the free list, and release presents all of its addresses across the chain in submission order.
- R6: Pool indices are handed out from recycled indices first, in the order they were freed, then from unused indices in ascending order starting at 0. Release frees every entry of the chain.
- R7: When a beat needs a new entry and none is free, new_ready_o stays low and the beat is held, not dropped, until a release frees an entry.
- R8: A wakeup that reaches zero takes the ready output before a zero-count insertion. In that cycle the insertion's last beat is stalled by new_ready_o low, and it is emitted in a later cycle.
- R9: While rel_valid_o is high and rel_ready_i is low, rel_addr_o and rel_valid_o hold their values. fin_ready_o is low for the whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_valid_i | input | 1 | New-task beat valid |
| new_ready_o | output | 1 | New-task beat accepted |
| new_func_i | input | FUNC_W | Function pointer, taken on the first beat |
| new_addr_i | input | ADDR_W | Parameter address of this beat |
| new_last_i | input | 1 | Last beat of the task |
| new_dep_i | input | CNT_W | Initial dependence count, taken on the last beat |
| wake_valid_i | input | 1 | Wakeup event for one task |
| wake_idx_i | input | IDX_W | Head index of the woken task |
| fin_valid_i | input | 1 | Finished-task notification |
| fin_ready_o | output | 1 | Notification accepted (no walk in progress) |
| fin_idx_i | input | IDX_W | Head index of the finished task |
| rel_valid_o | output | 1 | Address release request valid |
| rel_ready_i | input | 1 | Release request taken |
| rel_addr_o | output | ADDR_W | Address to release |
| rdy_valid_o | output | 1 | Ready task emitted |
| rdy_func_o | output | FUNC_W | Function pointer of the ready task |
| rdy_idx_o | output | IDX_W | Pool index of the ready task |
| err_o | output | 1 | Wakeup on a zero count |

## Verification
The hardest case to reach is an exhausted pool. To get there, every index must be in use, and some of those indices must be recycled ones. The bench first runs a chained task and a second task through release, so that the recycled queue holds indices in a known order. It then fills the remaining capacity with single-parameter tasks that wait on one dependency. With an extra beat held at the input, it wakes and releases one chosen entry to open a slot. The same full pool sets up the priority collision: a wakeup that reaches zero is driven in the same cycle as the last beat of a zero-count task.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {REL_IDLE, REL_WALK} rel_st_e;
endpackage

// File: rtl/tp_free_list.sv
module tp_free_list #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  output logic             avail_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] rd_ptr, wr_ptr;
  logic [IDX_W:0]   count, fresh;
  logic             use_rec;

  assign use_rec = (count != '0);
  assign avail_o = use_rec || (32'(fresh) < DEPTH);
  assign idx_o   = use_rec ? mem[rd_ptr] : fresh[IDX_W-1:0];

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      fresh  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i && use_rec) rd_ptr <= nxt(rd_ptr);
      if (pop_i && !use_rec) fresh <= fresh + 1'b1;
      count <= count + (push_i ? 1'b1 : 1'b0) - ((pop_i && use_rec) ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= push_idx_i;
  end

  assert_pop_avail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> avail_o);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (32'(count) < DEPTH));
endmodule

// File: rtl/tp_dep_count.sv
module tp_dep_count #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_we_i,
  input  logic [IDX_W-1:0] init_idx_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic             wake_i,
  input  logic [IDX_W-1:0] wake_idx_i,
  output logic             zero_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_mem [DEPTH];
  logic [CNT_W-1:0] cur;
  logic             under;

  assign cur    = cnt_mem[wake_idx_i];
  assign under  = wake_i && (cur == '0);
  assign zero_o = wake_i && (cur == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_mem[i] <= '0;
      err_o <= 1'b0;
    end else begin
      if (init_we_i) cnt_mem[init_idx_i] <= init_cnt_i;
      if (wake_i && !under) cnt_mem[wake_idx_i] <= cur - CNT_W'(1);
      err_o <= under;
    end
  end

  assert_err_from_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wake_i));
  assert_zero_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> !err_o);
endmodule

// File: rtl/task_pool.sv
module task_pool
  import tp_pkg::*;
#(
  parameter int POOL_DEPTH = 1024,
  parameter int PARAMS     = 8,
  parameter int ADDR_W     = 32,
  parameter int FUNC_W     = 32,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(POOL_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_valid_i,
  output logic              new_ready_o,
  input  logic [FUNC_W-1:0] new_func_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  input  logic              new_last_i,
  input  logic [CNT_W-1:0]  new_dep_i,
  input  logic              wake_valid_i,
  input  logic [IDX_W-1:0]  wake_idx_i,
  input  logic              fin_valid_i,
  output logic              fin_ready_o,
  input  logic [IDX_W-1:0]  fin_idx_i,
  output logic              rel_valid_o,
  input  logic              rel_ready_i,
  output logic [ADDR_W-1:0] rel_addr_o,
  output logic              rdy_valid_o,
  output logic [FUNC_W-1:0] rdy_func_o,
  output logic [IDX_W-1:0]  rdy_idx_o,
  output logic              err_o
);
  localparam int SLOT_W = $clog2(PARAMS + 1);
  localparam int SEL_W  = (PARAMS > 1) ? $clog2(PARAMS) : 1;

  logic [FUNC_W-1:0]        func_mem [POOL_DEPTH];
  logic [PARAMS*ADDR_W-1:0] par_mem  [POOL_DEPTH];
  logic [SLOT_W-1:0]        fill_mem [POOL_DEPTH];
  logic [IDX_W-1:0]         nxt_mem  [POOL_DEPTH];
  logic                     nxt_vld  [POOL_DEPTH];

  // free list
  logic             fl_avail, fl_pop, fl_push;
  logic [IDX_W-1:0] fl_idx;

  // insertion state
  logic              ins_active;
  logic [IDX_W-1:0]  ins_head, ins_cur;
  logic [SLOT_W-1:0] ins_slot;
  logic [FUNC_W-1:0] ins_func;
  logic              need_alloc, ins_zero, new_fire;
  logic [IDX_W-1:0]  wr_idx, head_eff;
  logic [SLOT_W-1:0] wr_slot;
  logic [SEL_W-1:0]  wr_sel;
  logic [FUNC_W-1:0] func_eff;

  // release state
  rel_st_e           rel_st;
  logic [IDX_W-1:0]  rel_cur;
  logic [SLOT_W-1:0] rel_slot;
  logic [SEL_W-1:0]  rel_sel;
  logic              rel_end;

  logic wake_zero;

  assign need_alloc  = !ins_active || (ins_slot == SLOT_W'(PARAMS));
  assign ins_zero    = new_last_i && (new_dep_i == '0);
  // a wakeup reaching zero owns the ready register this cycle
  assign new_ready_o = (!need_alloc || fl_avail) && !(ins_zero && wake_zero);
  assign new_fire    = new_valid_i && new_ready_o;
  assign fl_pop      = new_fire && need_alloc;
  assign wr_idx      = need_alloc ? fl_idx : ins_cur;
  assign wr_slot     = need_alloc ? '0 : ins_slot;
  assign wr_sel      = wr_slot[SEL_W-1:0];
  assign head_eff    = ins_active ? ins_head : fl_idx;
  assign func_eff    = ins_active ? ins_func : new_func_i;

  assign rel_valid_o = (rel_st == REL_WALK);
  assign fin_ready_o = (rel_st == REL_IDLE);
  assign rel_sel     = rel_slot[SEL_W-1:0];
  assign rel_addr_o  = par_mem[rel_cur][rel_sel*ADDR_W +: ADDR_W];
  assign rel_end     = ((rel_slot + SLOT_W'(1)) == fill_mem[rel_cur]);
  assign fl_push     = rel_valid_o && rel_ready_i && rel_end;

  tp_free_list #(.DEPTH(POOL_DEPTH)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (fl_pop),
    .push_i     (fl_push),
    .push_idx_i (rel_cur),
    .avail_o    (fl_avail),
    .idx_o      (fl_idx)
  );

  tp_dep_count #(.DEPTH(POOL_DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_we_i  (new_fire && new_last_i),
    .init_idx_i (head_eff),
    .init_cnt_i (new_dep_i),
    .wake_i     (wake_valid_i),
    .wake_idx_i (wake_idx_i),
    .zero_o     (wake_zero),
    .err_o      (err_o)
  );

  // insertion control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_active <= 1'b0;
      ins_head   <= '0;
      ins_cur    <= '0;
      ins_slot   <= '0;
      ins_func   <= '0;
    end else if (new_fire) begin
      ins_active <= !new_last_i;
      if (!ins_active) begin
        ins_head <= fl_idx;
        ins_func <= new_func_i;
      end
      ins_cur  <= wr_idx;
      ins_slot <= wr_slot + SLOT_W'(1);
    end
  end

  // pool storage
  always_ff @(posedge clk_i) begin
    if (new_fire) begin
      par_mem[wr_idx][wr_sel*ADDR_W +: ADDR_W] <= new_addr_i;
      fill_mem[wr_idx] <= wr_slot + SLOT_W'(1);
      if (need_alloc) begin
        nxt_vld[fl_idx] <= 1'b0;
        if (ins_active) begin
          nxt_mem[ins_cur] <= fl_idx;
          nxt_vld[ins_cur] <= 1'b1;
        end else begin
          func_mem[fl_idx] <= new_func_i;
        end
      end
    end
  end

  // release walk over the chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_st   <= REL_IDLE;
      rel_cur  <= '0;
      rel_slot <= '0;
    end else if (rel_st == REL_IDLE) begin
      if (fin_valid_i) begin
        rel_st   <= REL_WALK;
        rel_cur  <= fin_idx_i;
        rel_slot <= '0;
      end
    end else if (rel_ready_i) begin
      if (rel_end) begin
        if (nxt_vld[rel_cur]) begin
          rel_cur  <= nxt_mem[rel_cur];
          rel_slot <= '0;
        end else begin
          rel_st <= REL_IDLE;
        end
      end else begin
        rel_slot <= rel_slot + SLOT_W'(1);
      end
    end
  end

  // ready output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_valid_o <= 1'b0;
      rdy_idx_o   <= '0;
      rdy_func_o  <= '0;
    end else begin
      rdy_valid_o <= wake_zero || (new_fire && ins_zero);
      if (wake_zero) begin
        rdy_idx_o  <= wake_idx_i;
        rdy_func_o <= func_mem[wake_idx_i];
      end else begin
        rdy_idx_o  <= head_eff;
        rdy_func_o <= func_eff;
      end
    end
  end

  assert_rdy_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o |-> $past(wake_valid_i || (new_fire && new_last_i)));
  assert_rel_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_o && !rel_ready_i) |=> (rel_valid_o && $stable(rel_addr_o)));
  assert_fin_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_o |-> !fin_ready_o);
  assert_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_zero && new_valid_i && ins_zero) |-> !new_ready_o);
endmodule

// File: tb/sim_task_pool.sv
module sim_task_pool;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NPAR  = 4;
  localparam int AW = 32, FW = 32, CW = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic new_valid = 0, new_last = 0;
  logic [FW-1:0] new_func = '0;
  logic [AW-1:0] new_addr = '0;
  logic [CW-1:0] new_dep = '0;
  logic wake_valid = 0, fin_valid = 0, rel_ready = 0;
  logic [IW-1:0] wake_idx = '0, fin_idx = '0;
  logic new_ready, fin_ready, rel_valid, rdy_valid, err;
  logic [AW-1:0] rel_addr;
  logic [FW-1:0] rdy_func;
  logic [IW-1:0] rdy_idx;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_pool #(.POOL_DEPTH(DEPTH), .PARAMS(NPAR), .ADDR_W(AW), .FUNC_W(FW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .new_valid_i(new_valid), .new_ready_o(new_ready), .new_func_i(new_func),
    .new_addr_i(new_addr), .new_last_i(new_last), .new_dep_i(new_dep),
    .wake_valid_i(wake_valid), .wake_idx_i(wake_idx),
    .fin_valid_i(fin_valid), .fin_ready_o(fin_ready), .fin_idx_i(fin_idx),
    .rel_valid_o(rel_valid), .rel_ready_i(rel_ready), .rel_addr_o(rel_addr),
    .rdy_valid_o(rdy_valid), .rdy_func_o(rdy_func), .rdy_idx_o(rdy_idx),
    .err_o(err)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [FW-1:0] f, input logic [AW-1:0] a, input logic l, input logic [CW-1:0] d);
    @(negedge clk);
    new_valid = 1; new_func = f; new_addr = a; new_last = l; new_dep = d;
    #1;
    for (int i = 0; i < 50 && !new_ready; i++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    new_valid = 0; new_last = 0;
  endtask

  task automatic insert(input logic [FW-1:0] f, input logic [AW-1:0] base, input int n, input logic [CW-1:0] d);
    for (int i = 0; i < n; i++) beat(f, base + AW'(i*4), (i == n-1), d);
  endtask

  task automatic wake(input int idx);
    @(negedge clk);
    wake_valid = 1; wake_idx = IW'(idx);
    @(posedge clk);
    @(negedge clk);
    wake_valid = 0;
  endtask

  task automatic check_rdy(input string req, input int idx, input logic [FW-1:0] f);
    chk(rdy_valid === 1'b1, req, rdy_valid, 1);
    chk(rdy_idx === IW'(idx), req, rdy_idx, idx);
    chk(rdy_func === f, req, rdy_func, f);
  endtask

  task automatic finish(input int idx, input int n, input logic [AW-1:0] base, input string req);
    @(negedge clk);
    fin_valid = 1; fin_idx = IW'(idx);
    @(posedge clk);
    @(negedge clk);
    fin_valid = 0;
    for (int k = 0; k < n; k++) begin
      chk(rel_valid === 1'b1, req, rel_valid, 1);
      chk(rel_addr === base + AW'(k*4), req, rel_addr, base + AW'(k*4));
      rel_ready = 1;
      @(posedge clk);
      @(negedge clk);
      rel_ready = 0;
    end
    chk(rel_valid === 1'b0 && fin_ready === 1'b1, req, {rel_valid, fin_ready}, 2'b01);
  endtask

  task automatic t_reset;
    chk(rdy_valid === 0 && err === 0 && rel_valid === 0, "R1", {rdy_valid, err, rel_valid}, 0);
    chk(new_ready === 1 && fin_ready === 1, "R1", {new_ready, fin_ready}, 2'b11);
  endtask

  task automatic t_zero_insert;
    insert(32'hA0, 32'h100, 1, 0);
    check_rdy("R2", 0, 32'hA0);
    @(negedge clk);
    chk(rdy_valid === 0, "R2 once", rdy_valid, 0);
    // release with stall on the handshake
    @(negedge clk);
    fin_valid = 1; fin_idx = 0;
    @(posedge clk);
    @(negedge clk);
    fin_valid = 0;
    chk(rel_valid === 1 && rel_addr === 32'h100 && fin_ready === 0, "R9", rel_addr, 32'h100);
    @(negedge clk);
    @(negedge clk);
    chk(rel_valid === 1 && rel_addr === 32'h100, "R9 hold", rel_addr, 32'h100);
    rel_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rel_ready = 0;
    chk(rel_valid === 0 && fin_ready === 1, "R9 end", rel_valid, 0);
  endtask

  task automatic t_count;
    insert(32'hB0, 32'h200, 1, 2);
    chk(rdy_valid === 0, "R3 no emit", rdy_valid, 0);
    wake(0);
    chk(rdy_valid === 0 && err === 0, "R3 first wake", {rdy_valid, err}, 0);
    wake(0);
    check_rdy("R3 zero", 0, 32'hB0);   // recycled index 0 also covers R6
    chk(err === 0, "R3 no err", err, 0);
    @(negedge clk);
    chk(rdy_valid === 0, "R3 once", rdy_valid, 0);
    wake(0);
    chk(err === 1 && rdy_valid === 0, "R4 underflow", {err, rdy_valid}, 2'b10);
    @(negedge clk);
    chk(err === 0, "R4 pulse", err, 0);
    wake(0);
    chk(err === 1 && rdy_valid === 0, "R4 unchanged", {err, rdy_valid}, 2'b10);
  endtask

  task automatic t_chain;
    insert(32'hC0, 32'h300, 10, 0);
    check_rdy("R5 chain head", 1, 32'hC0);
    finish(1, 10, 32'h300, "R5 walk");
    finish(0, 1, 32'h200, "R6 release");
  endtask

  task automatic t_full;
    // recycled order 1,2,3,0 then unused 4..7
    for (int i = 0; i < 8; i++) insert(32'h50 + FW'(i), 32'h500 + AW'(i*4), 1, 1);
    @(negedge clk);
    new_valid = 1; new_func = 32'h99; new_addr = 32'h900; new_last = 1; new_dep = 0;
    #1;
    chk(new_ready === 0, "R7 stall", new_ready, 0);
    @(negedge clk);
    @(negedge clk);
    chk(new_ready === 0 && rdy_valid === 0, "R7 held", new_ready, 0);
    wake(5);
    check_rdy("R6 order", 5, 32'h55);
    finish(5, 1, 32'h514, "R6 free");
    chk(new_ready === 1, "R7 resume", new_ready, 1);
    @(posedge clk);
    @(negedge clk);
    new_valid = 0; new_last = 0;
    check_rdy("R7 not dropped", 5, 32'h99);
  endtask

  task automatic t_prio;
    finish(5, 1, 32'h900, "R8 setup");
    @(negedge clk);
    wake_valid = 1; wake_idx = 1;
    new_valid = 1; new_func = 32'hF0; new_addr = 32'hF00; new_last = 1; new_dep = 0;
    #1;
    chk(new_ready === 0, "R8 stall", new_ready, 0);
    @(posedge clk);
    @(negedge clk);
    wake_valid = 0;
    check_rdy("R8 wake first", 1, 32'h50);
    #1;
    chk(new_ready === 1, "R8 release", new_ready, 1);
    @(posedge clk);
    @(negedge clk);
    new_valid = 0; new_last = 0;
    check_rdy("R8 insert later", 5, 32'hF0);
    @(negedge clk);
    chk(rdy_valid === 0, "R8 once", rdy_valid, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_insert();
    t_count();
    t_chain();
    t_full();
    t_prio();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule